// File: doc/BRIEF.md
# Write-Through Cache with One-Word Subblocks

This block is a direct-mapped, write-through data cache. Each line holds several one-word subblocks under a single tag, and each subblock has its own valid bit. A store never reads the line from memory. It writes its word into the cache at once and updates the tag and valid bits. If the tag differs, the line is re-tagged and only the stored word is kept valid. This is safe because memory always receives every store and so never holds stale data.

A load hits only when the tag matches and the addressed word is valid. On a load miss the cache reads that one word from memory and installs it. The install follows the same tag rule as a store. Every store is placed in a one-entry write path that drains to memory. The CPU waits while that path is occupied and it issues a store or a load miss. A load hit may proceed while a write is still draining.

Addresses are word addresses. The word offset is in the low bits, the line index is in the bits above it, and the tag is in the remaining high bits. The default geometry is 32 lines of 4 words, with 32-bit words.

Top module: `wtSubblockCache`

## Requirements
- R1: After reset every subblock is invalid, so the first load of any address misses and causes one memory read.
- R2: A load whose line tag matches and whose word is valid completes in its first cycle. It returns the cached word with cpuReady high and issues no memory read.
- R3: A load miss issues exactly one memory read (memWe low) of the addressed word. In the acknowledge cycle it returns the memory word with cpuReady high. The word is then valid, so a repeat load of it hits.
- R4: A store whose tag matches writes the word and sets its valid bit, whether or not that bit was already set. A later load of that word hits and returns the stored value.
- R5: A store or a load fill whose tag mismatches the line replaces the tag and marks only the written word valid. A later load of any other word of that line misses.
- R6: A store never causes a memory read, whether it hits or misses.
- R7: Each accepted store completes with cpuReady high in its first cycle. It later produces exactly one memory write with the store's address and data, and the memory address and write flag stay stable until memAck.
- R8: While a store is still waiting in the write path, a further store is held with cpuReady low until memAck frees the path.
- R9: A load miss issues its memory read only after any pending store write has been acknowledged.
- R10: A load that hits completes even while a store is draining to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | CPU request, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Store data |
| cpuRdata | output | DATA_W | Load data, valid with cpuReady |
| cpuReady | output | 1 | Request completes this cycle |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write-through store, 0 = word read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with memAck |
| memAck | input | 1 | Memory completes this cycle |

## Verification
A load hit and an accepted store raise cpuReady in the same cycle as the request. The bench samples one time unit after the falling edge on which it drives the request. A load miss completes in the cycle in which memAck arrives, and that cycle depends on the latency the bench memory model applies. The bench waits for cpuReady sample by sample and judges hit or miss from the number of memory reads counted at the completing rising edge. Write-through traffic is checked by waiting for the write count to advance and then comparing the model memory contents.

// File: rtl/wtcPkg.sv
package wtcPkg;
  typedef enum logic {CTL_IDLE, CTL_FETCH} ctlState_t;

  typedef struct packed {
    logic cacheWrite;
    logic fromMem;
    logic wbLoad;
    logic fetchReq;
  } ctlStrobes_t;
endpackage

// File: rtl/wtcDatapath.sv
module wtcDatapath
  import wtcPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              wbBusy,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  tagMem   [LINES];
  logic [WORDS-1:0]  validMem [LINES];
  logic [DATA_W-1:0] dataMem  [LINES*WORDS];

  logic [OFF_W-1:0]  wordOff;
  logic [IDX_W-1:0]  lineIdx;
  logic [TAG_W-1:0]  addrTag;
  logic              tagMatch;
  logic [DATA_W-1:0] fillData;
  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;

  assign wordOff  = cpuAddr[OFF_W-1:0];
  assign lineIdx  = cpuAddr[OFF_W +: IDX_W];
  assign addrTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign tagMatch = (tagMem[lineIdx] == addrTag);
  assign hit      = tagMatch & validMem[lineIdx][wordOff];
  assign fillData = strobes.fromMem ? memRdata : cpuWdata;
  assign cpuRdata = strobes.fromMem ? memRdata : dataMem[{lineIdx, wordOff}];

  // tag and per-word valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        validMem[i] <= '0;
        tagMem[i]   <= '0;
      end
    end else if (strobes.cacheWrite) begin
      if (tagMatch) begin
        validMem[lineIdx][wordOff] <= 1'b1;
      end else begin
        tagMem[lineIdx]   <= addrTag;
        validMem[lineIdx] <= WORDS'(1) << wordOff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.cacheWrite) dataMem[{lineIdx, wordOff}] <= fillData;
  end

  // one-entry write-through path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbBusy <= 1'b0;
      wbAddr <= '0;
      wbData <= '0;
    end else if (strobes.wbLoad) begin
      wbBusy <= 1'b1;
      wbAddr <= cpuAddr;
      wbData <= cpuWdata;
    end else if (wbBusy && memAck) begin
      wbBusy <= 1'b0;
    end
  end

  assign memReq   = wbBusy | strobes.fetchReq;
  assign memWe    = wbBusy;
  assign memAddr  = wbBusy ? wbAddr : cpuAddr;
  assign memWdata = wbData;

  assert_mismatch_single_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cacheWrite && !tagMatch |=> $countones(validMem[$past(lineIdx)]) == 1);

  assert_store_forwarded_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wbLoad |=> memReq && memWe && memAddr == $past(cpuAddr)
                       && memWdata == $past(cpuWdata));

  assert_mem_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));
endmodule

// File: rtl/wtcControl.sv
module wtcControl
  import wtcPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        hit,
  input  logic        wbBusy,
  input  logic        memAck,
  output ctlStrobes_t strobes,
  output logic        cpuReady
);
  ctlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CTL_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes   = '0;
    cpuReady  = 1'b0;
    stateNext = state;
    case (state)
      CTL_IDLE: begin
        if (cpuReq) begin
          if (cpuWe) begin
            if (!wbBusy) begin
              strobes.cacheWrite = 1'b1;
              strobes.wbLoad     = 1'b1;
              cpuReady           = 1'b1;
            end
          end else if (hit) begin
            cpuReady = 1'b1;
          end else if (!wbBusy) begin
            stateNext = CTL_FETCH;
          end
        end
      end
      CTL_FETCH: begin
        strobes.fetchReq = 1'b1;
        if (memAck) begin
          strobes.cacheWrite = 1'b1;
          strobes.fromMem    = 1'b1;
          cpuReady           = 1'b1;
          stateNext          = CTL_IDLE;
        end
      end
      default: stateNext = CTL_IDLE;
    endcase
  end

  assert_store_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && wbBusy |-> !cpuReady);

  assert_fetch_after_drain_R9: assert property (@(posedge clk) disable iff (!rstN)
    state == CTL_FETCH |-> !wbBusy);
endmodule

// File: rtl/wtSubblockCache.sv
module wtSubblockCache
  import wtcPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  ctlStrobes_t strobes;
  logic        hit;
  logic        wbBusy;

  wtcControl uCtl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .wbBusy(wbBusy), .memAck(memAck), .strobes(strobes), .cpuReady(cpuReady)
  );

  wtcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memAck(memAck), .memRdata(memRdata), .hit(hit),
    .wbBusy(wbBusy), .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  assert_store_no_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && cpuReady |=> !(memReq && !memWe));
endmodule

// File: tb/sim_wtSubblockCache.sv
module sim_wtSubblockCache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic [DW-1:0] cpuRdata;
  logic cpuReady, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic memAck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtSubblockCache #(.ADDR_W(AW), .DATA_W(DW), .LINES(4), .WORDS(4)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0, fails = 0, cycles = 0;
  int memReads = 0, memWrites = 0, writesAtRead = 0;
  int lat = 1, waitCnt = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] expMem [256];
  logic [3:0] refTag [4];
  logic [3:0] refValid [4];

  function automatic logic [DW-1:0] initWord(int a);
    return 32'hC0DE_0000 + DW'(a * 7);
  endfunction

  // memory model: ack after lat extra cycles, driven on falling edge
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      if (waitCnt >= lat) begin
        memAck   <= 1'b1;
        memRdata <= mem[memAddr];
        waitCnt  <= 0;
      end else waitCnt <= waitCnt + 1;
    end else memAck <= 1'b0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        memWrites <= memWrites + 1;
      end else begin
        memReads <= memReads + 1;
        writesAtRead <= memWrites;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic doLoad(input int a, output logic [DW-1:0] d, output bit miss, output int waited);
    int r0 = memReads;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = AW'(a);
    #1; waited = 0;
    while (!cpuReady && waited < 200) begin @(negedge clk); #1; waited++; end
    d = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0;
    miss = (memReads != r0);
  endtask

  task automatic doStore(input int a, input logic [DW-1:0] d, input bit drain,
                         output int waited, output bit readSeen);
    int r0 = memReads;
    int w0 = memWrites;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = AW'(a); cpuWdata = d;
    #1; waited = 0;
    while (!cpuReady && waited < 200) begin @(negedge clk); #1; waited++; end
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
    expMem[a] = d;
    if (drain) begin
      int g = 0;
      while (memWrites == w0 && g < 200) begin @(posedge clk); #1; g++; end
    end
    readSeen = (memReads != r0);
  endtask

  // reference update for store or fill, from R4/R5
  task automatic refInstall(input int a);
    int l = (a >> 2) & 3;
    int w = a & 3;
    int t = a >> 4;
    if (refTag[l] == 4'(t)) refValid[l][w] = 1'b1;
    else begin refTag[l] = 4'(t); refValid[l] = 4'(1 << w); end
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    bit miss, rs;
    int wt, w0;
    for (int a = 0; a < 256; a++) begin mem[a] = initWord(a); expMem[a] = initWord(a); end
    for (int l = 0; l < 4; l++) begin refTag[l] = 0; refValid[l] = 0; end
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    #1;
    check(cpuReady == 1'b0 && memReq == 1'b0, "R1 reset outputs", {cpuReady, memReq}, 0);

    // R1/R3: first touch of all 16 words of tag 0 misses, repeat hits (R2)
    for (int a = 0; a < 16; a++) begin
      lat = a % 3;
      doLoad(a, d, miss, wt);
      check(miss, "R1 first load misses", miss, 1);
      check(d == initWord(a), "R3 fill data", d, initWord(a));
      doLoad(a, d, miss, wt);
      check(!miss && wt == 0, "R2 hit no read, first cycle", {miss, 8'(wt)}, 0);
      check(d == initWord(a), "R3 installed word valid", d, initWord(a));
      refInstall(a);
    end

    // R5 via load fill: tag 1 in line 0 evicts words 1..3
    lat = 1;
    doLoad(16, d, miss, wt); refInstall(16);
    check(miss && d == initWord(16), "R5 fill mismatch", d, initWord(16));
    doLoad(1, d, miss, wt); refInstall(1);
    check(miss, "R5 other word invalidated by fill", miss, 1);

    // R4: store with tag match to invalid then valid word
    doLoad(17, d, miss, wt); refInstall(17); // re-tag line 0 to tag 1 (miss)
    doStore(18, 32'hAAAA_0018, 1, wt, rs); refInstall(18);
    check(!rs, "R6 store miss no read", rs, 0);
    doLoad(18, d, miss, wt);
    check(!miss && d == 32'hAAAA_0018, "R4 store to invalid word", d, 32'hAAAA_0018);
    doStore(18, 32'hBBBB_0018, 1, wt, rs);
    doLoad(18, d, miss, wt);
    check(!miss && d == 32'hBBBB_0018, "R4 store to valid word", d, 32'hBBBB_0018);
    check(mem[18] == 32'hBBBB_0018, "R7 write-through data", mem[18], 32'hBBBB_0018);

    // R5 via store: tag 2 line 0 word 2
    doStore(34, 32'h1234_5678, 1, wt, rs); refInstall(34);
    check(!rs && wt == 0, "R6/R7 store accepted first cycle, no read", {rs, 8'(wt)}, 0);
    doLoad(34, d, miss, wt);
    check(!miss && d == 32'h1234_5678, "R5 stored word valid", d, 32'h1234_5678);
    doLoad(17, d, miss, wt); refInstall(17);
    check(miss && d == initWord(17), "R5 old tag misses", d, initWord(17));
    doLoad(34, d, miss, wt); refInstall(34);
    check(miss && d == 32'h1234_5678, "R5 memory kept current copy", d, 32'h1234_5678);

    // R8: back-to-back stores, second held
    lat = 2;
    w0 = memWrites;
    doStore(40, 32'h0000_0040, 0, wt, rs); refInstall(40);
    doStore(41, 32'h0000_0041, 0, wt, rs); refInstall(41);
    check(wt >= 1, "R8 second store held", wt, 1);
    repeat (10) @(posedge clk); #1;
    check(memWrites == w0 + 2, "R7 one write per store", memWrites, w0 + 2);

    // R10: hit while a store drains
    doStore(42, 32'h0000_0042, 0, wt, rs); refInstall(42);
    doLoad(41, d, miss, wt);
    check(!miss && wt == 0 && d == 32'h0000_0041, "R10 hit during drain", d, 32'h41);

    // R9: load miss behind a pending store
    repeat (10) @(posedge clk);
    w0 = memWrites;
    doStore(60, 32'h0000_0060, 0, wt, rs); refInstall(60);
    doLoad(61, d, miss, wt); refInstall(61);
    check(miss && writesAtRead == w0 + 1, "R9 read after write", writesAtRead, w0 + 1);

    // sweep over all addresses, mixed ops, reference model from R2..R5
    for (int i = 0; i < 256; i++) begin
      int a = (i * 37) % 256;
      int l = (a >> 2) & 3;
      int w = a & 3;
      bit expMiss;
      lat = i % 3;
      if (i % 3 == 0) begin
        doStore(a, 32'h5A00_0000 + DW'(i), 1, wt, rs); refInstall(a);
        check(!rs && mem[a] == expMem[a], "R6/R7 sweep store", mem[a], expMem[a]);
      end else begin
        expMiss = !(refValid[l][w] && refTag[l] == 4'(a >> 4));
        doLoad(a, d, miss, wt); refInstall(a);
        check(miss == expMiss && d == expMem[a], "R2/R3/R5 sweep load", {miss, d}, {expMiss, expMem[a]});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule